// File: doc/BRIEF.md
# Near/Far Partitioned Cache Lookup Controller

This block fronts a last-level cache that is built from two equally sized partitions, seen from the point of view of a single requesting client. The client's own partition is its "near" side, and the other partition is its "far" side. A static input picks which partition is near. Every line address also has a fixed home partition, and that home is chosen by address in coarse 8 KiB chunks, alternating chunk by chunk.

A read request is a single line address, passed through a valid/ready handshake. The controller searches the near partition first. It searches the far partition only when the near one misses. When both miss, it issues a single request on a fixed-latency backing-memory port.

The three outcomes are handled as follows:
- A near hit answers after a parameterised short latency.
- A far hit answers after a longer latency, and the line is also copied into the near partition. The line can then live in both partitions.
- A line fetched from memory is installed only in its home partition, even when that home is the far side. It is never moved toward the requester.

Three counters record how each completed request was served.

Top module: `nf_cache_ctrl`

## Requirements
- R1: After reset `req_ready` is high. It goes low on the cycle after a request is accepted, and it stays low until the response is taken. Only one request is in flight at a time.
- R2: A line held in the near partition is answered with `rsp_src` = 0, exactly NEAR_LAT cycles after the accepting clock edge, with the stored data.
- R3: A line that misses near but hits far is answered with `rsp_src` = 1, exactly FAR_LAT cycles after acceptance, with the stored data.
- R4: A far hit also writes the line into the near partition, so the next request for that line is a near hit.
- R5: A line that misses both partitions produces exactly one `mem_req_valid` pulse, one cycle wide, carrying the line-aligned address (low 6 bits zero). The response returns the memory data with `rsp_src` = 2.
- R6: A memory fill is installed only in the line's home partition, which is address bit 13 (0 or 1). If the home is the far side, the next request for that line is a far hit.
- R7: `self_part` (0 or 1) names the near partition, and it is sampled when a request is accepted. A line that has been duplicated by a far-hit copy hits near from either side.
- R8: Each partition is direct-mapped with 64-byte lines. The index is taken from address bits [6 +: log2(LINES)] and the tag from the bits above. An install replaces whatever line sits at that index.
- R9: When a response is taken, exactly one of `cnt_near`, `cnt_far` or `cnt_fill` increments, selected by `rsp_src`.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_src` hold steady.
- R11: Reset leaves every line invalid, every counter at zero, `rsp_valid` low and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_part | input | 1 | Partition number that is near for this client |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request may be accepted |
| req_addr | input | ADDR_W | Byte address of the line to read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Client takes the response |
| rsp_data | output | DATA_W | Line data |
| rsp_src | output | 2 | 0 near hit, 1 far hit, 2 memory fill |
| mem_req_valid | output | 1 | Single-cycle backing-memory read request |
| mem_req_addr | output | ADDR_W | Line-aligned memory address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |
| cnt_near | output | STAT_W | Near-hit count |
| cnt_far | output | STAT_W | Far-hit count |
| cnt_fill | output | STAT_W | Memory-fill count |

## Verification
A lost or misplaced install does not show at the ports right away. It shows on the next request for that line or index: the `rsp_src` is wrong, the latency is wrong (NEAR_LAT against FAR_LAT), or a memory request appears that should not. For that reason each scenario re-reads lines after every copy, fill and eviction. A bad tag or valid bit becomes visible within one request. A counter or latency-timer fault is visible on the response of the request that caused it. Switching `self_part` exposes any copy that went to the wrong partition.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    SRC_NEAR = 2'd0,
    SRC_FAR  = 2'd1,
    SRC_MEM  = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MWAIT,
    ST_RESP
  } st_e;

  // Home partition of a line address: one bit of the line address,
  // picked so that chunks of 2**chunk_bits bytes alternate.
  function automatic logic home_bit(input logic [63:0] line_addr,
                                    input int unsigned sel_pos);
    return line_addr[sel_pos];
  endfunction

  // Index field of a line address for a direct-mapped array.
  function automatic logic [15:0] line_index(input logic [63:0] line_addr,
                                             input int unsigned idx_w);
    return 16'(line_addr & ((64'd1 << idx_w) - 64'd1));
  endfunction

endpackage

// File: rtl/nfc_part.sv
module nfc_part #(
  parameter int LA_W   = 26,
  parameter int DATA_W = 64,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   lk_line,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [LA_W-1:0]   wr_line,
  input  logic [DATA_W-1:0] wr_data
);
  import nfc_pkg::*;

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LA_W - IDX_W;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic [15:0]      lk_idx_full, wr_idx_full;
  logic [15:0]      unused_idx_hi;

  always_comb begin
    lk_idx_full   = line_index(64'(lk_line), IDX_W);
    wr_idx_full   = line_index(64'(wr_line), IDX_W);
    lk_idx        = lk_idx_full[IDX_W-1:0];
    wr_idx        = wr_idx_full[IDX_W-1:0];
    lk_tag        = lk_line[LA_W-1:IDX_W];
    wr_tag        = wr_line[LA_W-1:IDX_W];
    unused_idx_hi = lk_idx_full ^ wr_idx_full;
  end

  assign hit     = vld[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign rd_data = data_mem[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (we) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  // R8
  install_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> vld[$past(wr_idx)]);

endmodule

// File: rtl/nfc_lat_timer.sv
module nfc_lat_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] target,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      target_q <= '0;
    end else if (start) begin
      cnt      <= CNT_W'(1);
      target_q <= target;
    end else if (run && !expire) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign expire = run && (cnt == target_q);

  // R2
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

endmodule

// File: rtl/nfc_stats.sv
module nfc_stats #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_near,
  input  logic              inc_far,
  input  logic              inc_fill,
  output logic [STAT_W-1:0] cnt_near,
  output logic [STAT_W-1:0] cnt_far,
  output logic [STAT_W-1:0] cnt_fill
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_near <= '0;
      cnt_far  <= '0;
      cnt_fill <= '0;
    end else begin
      if (inc_near) cnt_near <= cnt_near + STAT_W'(1);
      if (inc_far)  cnt_far  <= cnt_far  + STAT_W'(1);
      if (inc_fill) cnt_fill <= cnt_fill + STAT_W'(1);
    end
  end

  // R9
  one_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_near, inc_far, inc_fill}));

endmodule

// File: rtl/nf_cache_ctrl.sv
module nf_cache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINES      = 16,
  parameter int LINE_BITS  = 6,
  parameter int CHUNK_BITS = 13,
  parameter int NEAR_LAT   = 200,
  parameter int FAR_LAT    = 350,
  parameter int STAT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              self_part,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_src,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [STAT_W-1:0] cnt_near,
  output logic [STAT_W-1:0] cnt_far,
  output logic [STAT_W-1:0] cnt_fill
);
  import nfc_pkg::*;

  localparam int LA_W     = ADDR_W - LINE_BITS;
  localparam int HOME_POS = CHUNK_BITS - LINE_BITS;
  localparam int CNT_W    = $clog2(FAR_LAT + 1) + 1;

  st_e             state;
  logic [LA_W-1:0] addr_q;
  logic            side_q;
  logic            hn_q, hf_q;

  // named internal events
  logic            req_fire, rsp_fire, lat_expire;
  logic            copy_ev, fill_ev;
  logic            cur_side, home_q;
  logic            near_hit, far_hit;
  logic [LA_W-1:0] lk_line;
  logic [LA_W-1:0] unused_low;

  logic [1:0]        p_hit, p_we;
  logic [DATA_W-1:0] p_rdata [2];
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  lat_target;

  assign unused_low = LA_W'(req_addr[LINE_BITS-1:0]);

  assign req_ready  = (state == ST_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign rsp_fire   = rsp_valid && rsp_ready;
  assign cur_side   = (state == ST_IDLE) ? self_part : side_q;
  assign lk_line    = (state == ST_IDLE) ? req_addr[ADDR_W-1:LINE_BITS] : addr_q;
  assign near_hit   = p_hit[cur_side];
  assign far_hit    = p_hit[!cur_side];
  assign home_q     = home_bit(64'(addr_q), HOME_POS);
  assign copy_ev    = (state == ST_WAIT) && lat_expire && !hn_q && hf_q;
  assign fill_ev    = (state == ST_MWAIT) && mem_rsp_valid;
  assign wr_data    = copy_ev ? p_rdata[!side_q] : mem_rsp_data;
  assign lat_target = near_hit ? CNT_W'(NEAR_LAT) : CNT_W'(FAR_LAT);
  assign mem_req_addr = {addr_q, {LINE_BITS{1'b0}}};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_part
      assign p_we[g] = (copy_ev && (side_q == 1'(g))) ||
                       (fill_ev && (home_q == 1'(g)));
      nfc_part #(
        .LA_W  (LA_W),
        .DATA_W(DATA_W),
        .LINES (LINES)
      ) u_part (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_line(lk_line),
        .hit    (p_hit[g]),
        .rd_data(p_rdata[g]),
        .we     (p_we[g]),
        .wr_line(addr_q),
        .wr_data(wr_data)
      );
    end
  endgenerate

  nfc_lat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (req_fire),
    .target(lat_target),
    .run   (state == ST_WAIT),
    .expire(lat_expire)
  );

  nfc_stats #(.STAT_W(STAT_W)) u_stats (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_near(rsp_fire && (rsp_src == SRC_NEAR)),
    .inc_far (rsp_fire && (rsp_src == SRC_FAR)),
    .inc_fill(rsp_fire && (rsp_src == SRC_MEM)),
    .cnt_near(cnt_near),
    .cnt_far (cnt_far),
    .cnt_fill(cnt_fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      addr_q        <= '0;
      side_q        <= 1'b0;
      hn_q          <= 1'b0;
      hf_q          <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_src       <= SRC_NEAR;
      mem_req_valid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_fire) begin
            addr_q <= req_addr[ADDR_W-1:LINE_BITS];
            side_q <= self_part;
            hn_q   <= near_hit;
            hf_q   <= far_hit;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (lat_expire) begin
            if (hn_q) begin
              rsp_valid <= 1'b1;
              rsp_data  <= p_rdata[side_q];
              rsp_src   <= SRC_NEAR;
              state     <= ST_RESP;
            end else if (hf_q) begin
              rsp_valid <= 1'b1;
              rsp_data  <= p_rdata[!side_q];
              rsp_src   <= SRC_FAR;
              state     <= ST_RESP;
            end else begin
              mem_req_valid <= 1'b1;
              state         <= ST_MWAIT;
            end
          end
        end
        ST_MWAIT: begin
          mem_req_valid <= 1'b0;
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rsp_data;
            rsp_src   <= SRC_MEM;
            state     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_fire) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_src)));

  // R5
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R4
  copy_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_ev |=> p_hit[side_q]);

  // R6
  fill_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |=> p_hit[home_q]);

endmodule

// File: tb/nf_cache_ctrl_tb.sv
module nf_cache_ctrl_tb;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 64;
  localparam int NEAR_LAT = 200;
  localparam int FAR_LAT  = 350;
  localparam int MEM_LAT  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic self_part = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0] rsp_src;
  logic mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic [15:0] cnt_near, cnt_far, cnt_fill;

  int checks = 0;
  int errors = 0;
  int mem_reqs = 0;
  logic [ADDR_W-1:0] last_mem_addr = '0;
  int exp_near = 0, exp_far = 0, exp_fill = 0;

  always #2 clk = ~clk;

  nf_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .self_part(self_part),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_src(rsp_src), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cnt_near(cnt_near), .cnt_far(cnt_far),
    .cnt_fill(cnt_fill)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a, a ^ 32'h5A5A_C3C3};
  endfunction

  function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a);
    return (a / 64) * 64;
  endfunction

  task automatic check(input string req, input logic ok,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // backing memory model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [ADDR_W-1:0] a;
        a = mem_req_addr;
        mem_reqs++;
        last_mem_addr = a;
        repeat (MEM_LAT) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // one request; exp_src 0 near, 1 far, 2 memory
  task automatic do_req(input string req, input logic [ADDR_W-1:0] a,
                        input int exp_src);
    int lat;
    int mr0;
    logic [DATA_W-1:0] d0;
    mr0 = mem_reqs;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 ready low while busy", !req_ready, req_ready, 0);
    lat = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    check({req, " source"}, rsp_src == 2'(exp_src), rsp_src, exp_src);
    check({req, " data"}, rsp_data == mem_word(align(a)), rsp_data, mem_word(align(a)));
    if (exp_src == 0) check("R2 near latency", lat == NEAR_LAT, lat, NEAR_LAT);
    if (exp_src == 1) check("R3 far latency", lat == FAR_LAT, lat, FAR_LAT);
    if (exp_src == 2) begin
      check("R5 one memory request", mem_reqs == mr0 + 1, mem_reqs - mr0, 1);
      check("R5 aligned address", last_mem_addr == align(a), last_mem_addr, align(a));
    end else begin
      check("R2 no memory request on hit", mem_reqs == mr0, mem_reqs - mr0, 0);
    end
    d0 = rsp_data;
    @(negedge clk);
    check("R10 response held", rsp_valid && rsp_data == d0, rsp_data, d0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (exp_src == 0) exp_near++;
    if (exp_src == 1) exp_far++;
    if (exp_src == 2) exp_fill++;
    check("R9 near count", cnt_near == 16'(exp_near), cnt_near, exp_near);
    check("R9 far count", cnt_far == 16'(exp_far), cnt_far, exp_far);
    check("R9 fill count", cnt_fill == 16'(exp_fill), cnt_fill, exp_fill);
    check("R1 ready back", req_ready, req_ready, 1);
  endtask

  task automatic t_reset;
    check("R11 ready after reset", req_ready, req_ready, 1);
    check("R11 no response", !rsp_valid, rsp_valid, 0);
    check("R11 no mem request", !mem_req_valid, mem_req_valid, 0);
    check("R11 counters zero", (cnt_near | cnt_far | cnt_fill) == 0, cnt_near, 0);
  endtask

  // home 0 is near for self_part 0
  task automatic t_near_home;
    do_req("R5 cold miss A", 32'h0000_0040, 2);
    do_req("R2 near hit A offset", 32'h0000_0058, 0);
  endtask

  // home of 0x2080 is partition 1 (bit 13 set)
  task automatic t_far_home;
    do_req("R6 cold miss B", 32'h0000_2080, 2);
    do_req("R6 fill stayed far", 32'h0000_2080, 1);
    do_req("R4 copied near", 32'h0000_2080, 0);
  endtask

  task automatic t_side_swap;
    self_part = 1'b1;
    do_req("R7 duplicate near from side 1", 32'h0000_2080, 0);
    do_req("R7 A far from side 1", 32'h0000_0040, 1);
    do_req("R4 A copied to side 1", 32'h0000_0040, 0);
    self_part = 1'b0;
  endtask

  // 0x440 shares index 1 and home 0 with 0x40
  task automatic t_evict;
    do_req("R8 conflict miss C", 32'h0000_0440, 2);
    do_req("R8 A evicted near, far copy", 32'h0000_0040, 1);
    do_req("R8 C evicted by copy", 32'h0000_0440, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_near_home();
    t_far_home();
    t_side_swap();
    t_evict();
    check("R5 total memory requests", mem_reqs == 4, mem_reqs, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule